// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

This block looks after a shared, active-low, open-drain reset pad that outside circuitry can pull low and that the chip itself also pulls low when an internal cause such as a watchdog timeout or a clock-monitor failure asks for a reset. Whatever starts a reset, the block pulls the pad low for a fixed window. It then lets go and waits a few cycles. Only then does it look at the pad again to decide whether something outside is still holding it. During the whole sequence a chip-wide reset is asserted. When the reset is released, a two-bit source code tells the boot logic which reset vector to fetch.

The pad level reaches the decision logic through a synchroniser chain. The pad driver is an output-enable, `pin_oe`: while it is high, the pad electronics pull the pin low. Internal requests are sampled levels. When both internal causes request in the same cycle, the clock monitor wins. An internal request that arrives while the pad is being driven, or during the wait after release, starts the sequence again and records the new cause.

Top module: `rst_pin_seq`

## Requirements
- R1: While `por_n` is low and right after it rises, `pin_oe` and `chip_rst` are 0 and `rst_src` is 2'b00.
- R2: A low pad level present at rising edge n, even for a single cycle, makes `pin_oe` and `chip_rst` high after edge n+2 (two synchroniser stages). A pad that stays high with no internal request leaves both outputs at 0.
- R3: For every start or restart of a sequence, `pin_oe` stays high for exactly DRIVE_CYC (8) consecutive cycles.
- R4: After `pin_oe` falls, the pad level present at the second rising edge is used to classify the reset. The decision is taken four edges after release. With a pad-only start, a low pulse of 13 cycles gives `rst_src` = 2'b01 and a pulse of 12 cycles does not.
- R5: A low pad pulse of 16 cycles or longer is always classified as external, with `rst_src` = 2'b01.
- R6: When the pad is high at the decision, `rst_src` gives the cause latched at the start: 2'b10 for watchdog, 2'b11 for clock monitor, and 2'b00 when only the pad started the sequence.
- R7: An internal request present at edge n, while no reset is active, makes `pin_oe` high after edge n. When both causes request together, the clock monitor (2'b11) wins. A pad that is held low during the decision still gives 2'b01.
- R8: `chip_rst` rises together with `pin_oe`. It stays high until one cycle after the decision, which is DRIVE_CYC+WAIT_CYC+1 (13) cycles after the last start.
- R9: `rst_src` changes only at a decision and holds its value while `chip_rst` is low.
- R10: An internal request during the drive or the wait phase restarts the drive phase at the next edge and replaces the latched cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Level seen at the reset pad |
| wdog_req | input | 1 | Watchdog reset request, level |
| cmon_req | input | 1 | Clock-monitor reset request, level |
| pin_oe | output | 1 | Pad pull-down enable; high drives the pad low |
| chip_rst | output | 1 | Chip-wide reset, active high |
| rst_src | output | 2 | Reset source: 00 unidentified, 01 external, 10 watchdog, 11 clock monitor |

## Verification
The bench sweeps the pad pulse width across the decision boundary with widths of 12 and 13 cycles. A design that samples one cycle early or late, or that miscounts the synchroniser delay, swaps those two verdicts. Restarts are exercised during both the drive phase and the wait phase. A design that ignores them gives a drive window of 8 cycles and the watchdog code, and one that restarts only from the drive phase ends the reset early after a wait-phase request. A simultaneous watchdog and clock-monitor request checks the priority, and an internal start with the pad held low checks that the pad level, not the latched cause, decides the source. Idle stretches after a sequence catch a source code that drifts or a reset that starts with no request.

// File: rtl/rps_pkg.sv
package rps_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } rps_state_e;

   typedef enum logic [1:0] {
      SRC_UNKNOWN = 2'b00,
      SRC_EXT     = 2'b01,
      SRC_WDOG    = 2'b10,
      SRC_CMON    = 2'b11
   } rps_src_e;

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rps_cause.sv
module rps_cause
   import rps_pkg::*;
#(
   parameter bit CMON_FIRST = 1'b1
) (
   input  logic     wdog_req,
   input  logic     cmon_req,
   output logic     any_req,
   output rps_src_e cause
);

   assign any_req = wdog_req | cmon_req;

   generate
      if (CMON_FIRST) begin : g_cmon_first
         always_comb begin
            if (cmon_req)      cause = SRC_CMON;
            else if (wdog_req) cause = SRC_WDOG;
            else               cause = SRC_UNKNOWN;
         end
      end else begin : g_wdog_first
         always_comb begin
            if (wdog_req)      cause = SRC_WDOG;
            else if (cmon_req) cause = SRC_CMON;
            else               cause = SRC_UNKNOWN;
         end
      end
   endgenerate

endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
   import rps_pkg::*;
#(
   parameter int DRIVE_CYC = 8,
   parameter int WAIT_CYC  = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pad_low,
   input  logic     int_req,
   input  rps_src_e int_cause,
   output logic     pin_oe,
   output logic     chip_rst,
   output rps_src_e src
);

   localparam int CNT_MAX = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
   localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
   localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYC - 1);
   localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CYC - 1);

   rps_state_e       state;
   logic [CNT_W-1:0] cnt;
   rps_src_e         cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         cause_q <= SRC_UNKNOWN;
         src     <= SRC_UNKNOWN;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (int_req) begin
                  state   <= ST_DRIVE;
                  cnt     <= '0;
                  cause_q <= int_cause;
               end else if (pad_low) begin
                  state   <= ST_DRIVE;
                  cnt     <= '0;
                  cause_q <= SRC_UNKNOWN;
               end
            end
            ST_DRIVE: begin
               if (int_req) begin
                  cnt     <= '0;
                  cause_q <= int_cause;
               end else if (cnt == DRIVE_LAST) begin
                  state <= ST_WAIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WAIT: begin
               if (int_req) begin
                  state   <= ST_DRIVE;
                  cnt     <= '0;
                  cause_q <= int_cause;
               end else if (cnt == WAIT_LAST) begin
                  state <= ST_DONE;
                  cnt   <= '0;
                  src   <= pad_low ? SRC_EXT : cause_q;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign pin_oe   = (state == ST_DRIVE);
   assign chip_rst = (state != ST_IDLE);

endmodule

// File: rtl/rst_pin_seq.sv
module rst_pin_seq
   import rps_pkg::*;
#(
   parameter int DRIVE_CYC   = 8,
   parameter int WAIT_CYC    = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit CMON_FIRST  = 1'b1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       pin_in,
   input  logic       wdog_req,
   input  logic       cmon_req,
   output logic       pin_oe,
   output logic       chip_rst,
   output logic [1:0] rst_src
);

   generate
      if (DRIVE_CYC < 2) begin : g_bad_drive
         $error("rst_pin_seq: DRIVE_CYC must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("rst_pin_seq: SYNC_STAGES must be at least 1");
      end
      if (WAIT_CYC <= SYNC_STAGES) begin : g_bad_wait
         $error("rst_pin_seq: WAIT_CYC must exceed SYNC_STAGES so the released pad is seen");
      end
   endgenerate

   logic     pin_sync;
   logic     any_int;
   rps_src_e int_cause;
   rps_src_e src_q;

   rps_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   rps_cause #(
      .CMON_FIRST (CMON_FIRST)
   ) u_cause (
      .wdog_req (wdog_req),
      .cmon_req (cmon_req),
      .any_req  (any_int),
      .cause    (int_cause)
   );

   rps_fsm #(
      .DRIVE_CYC (DRIVE_CYC),
      .WAIT_CYC  (WAIT_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (por_n),
      .pad_low   (~pin_sync),
      .int_req   (any_int),
      .int_cause (int_cause),
      .pin_oe    (pin_oe),
      .chip_rst  (chip_rst),
      .src       (src_q)
   );

   assign rst_src = src_q;

endmodule

// File: rtl/rst_pin_seq_chk.sv
module rst_pin_seq_chk #(
   parameter int DRIVE_CYC = 8,
   parameter int WAIT_CYC  = 4
) (
   input logic       clk,
   input logic       por_n,
   input logic       wdog_req,
   input logic       cmon_req,
   input logic       pin_oe,
   input logic       chip_rst,
   input logic [1:0] rst_src
);

   localparam int CW = $clog2(DRIVE_CYC + WAIT_CYC + 2) + 1;

   logic [CW-1:0] oe_run;
   logic [CW-1:0] tail_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         oe_run   <= '0;
         tail_run <= '0;
      end else begin
         oe_run   <= pin_oe ? ((wdog_req | cmon_req) ? '0 : oe_run + 1'b1) : '0;
         tail_run <= (chip_rst && !pin_oe) ? tail_run + 1'b1 : '0;
      end
   end

   // R3: every drive window is exactly DRIVE_CYC long
   a_r3_drive_len: assert property (@(posedge clk) disable iff (!por_n)
      $fell(pin_oe) |-> (oe_run == CW'(DRIVE_CYC)));

   // R3: the drive window never runs past DRIVE_CYC
   a_r3_drive_bound: assert property (@(posedge clk) disable iff (!por_n)
      pin_oe |-> (oe_run < CW'(DRIVE_CYC)));

   // R8: reset is released WAIT_CYC+1 cycles after the pad is let go
   a_r8_tail_len: assert property (@(posedge clk) disable iff (!por_n)
      $fell(chip_rst) |-> (tail_run == CW'(WAIT_CYC + 1)));

   // R8: the pad is never driven outside the chip reset
   a_r8_oe_inside: assert property (@(posedge clk) disable iff (!por_n)
      pin_oe |-> chip_rst);

   // R9: the source code holds while the chip is out of reset
   a_r9_src_hold: assert property (@(posedge clk) disable iff (!por_n)
      (!chip_rst && !$past(chip_rst)) |-> $stable(rst_src));

   // R7: an internal request outside a reset drives the pad on the next cycle
   a_r7_int_start: assert property (@(posedge clk) disable iff (!por_n)
      (!chip_rst && (wdog_req || cmon_req)) |=> pin_oe);

endmodule

bind rst_pin_seq rst_pin_seq_chk #(
   .DRIVE_CYC (DRIVE_CYC),
   .WAIT_CYC  (WAIT_CYC)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .wdog_req (wdog_req),
   .cmon_req (cmon_req),
   .pin_oe   (pin_oe),
   .chip_rst (chip_rst),
   .rst_src  (rst_src)
);

// File: tb/rst_pin_seq_bench.sv
module rst_pin_seq_bench;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_n = 1'b1;
   logic       wdog = 1'b0;
   logic       cmon = 1'b0;
   logic       pin_oe;
   logic       chip_rst;
   logic [1:0] src;
   logic       pad;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   assign pad = ext_n & ~pin_oe;

   rst_pin_seq u_rst_pin_seq (
      .clk      (clk),
      .por_n    (por_n),
      .pin_in   (pad),
      .wdog_req (wdog),
      .cmon_req (cmon),
      .pin_oe   (pin_oe),
      .chip_rst (chip_rst),
      .rst_src  (src)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_ext(input int width);
      ext_n = 1'b0;
      repeat (width) @(negedge clk);
      ext_n = 1'b1;
   endtask

   task automatic measure(output int lat, output int oe_len, output int rst_len,
                          output int src_v, output int oe_at_start);
      lat = 0;
      oe_len = 0;
      rst_len = 0;
      oe_at_start = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!chip_rst && lat < 40);
      oe_at_start = int'(pin_oe);
      while (chip_rst && rst_len < 100) begin
         rst_len++;
         if (pin_oe) oe_len++;
         @(negedge clk);
      end
      src_v = int'(src);
   endtask

   task automatic settle();
      int quiet = 0;
      for (int i = 0; i < 300 && quiet < 20; i++) begin
         @(negedge clk);
         quiet = chip_rst ? 0 : quiet + 1;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "pin_oe in reset", int'(pin_oe), 0);
      check("R1", "chip_rst in reset", int'(chip_rst), 0);
      check("R1", "rst_src in reset", int'(src), 0);
      por_n = 1'b1;
      begin
         int seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (chip_rst || pin_oe) seen++;
         end
         check("R2", "activity with idle pad", seen, 0);
      end
      check("R1", "rst_src after release", int'(src), 0);
   endtask

   task automatic t_ext(input int width, input int exp_src, input string req);
      int lat, oe_len, rst_len, src_v, co;
      fork
         pulse_ext(width);
         measure(lat, oe_len, rst_len, src_v, co);
      join
      check("R2", $sformatf("pad start latency w=%0d", width), lat, 3);
      check("R8", "pin_oe with chip_rst rise", co, 1);
      check("R3", $sformatf("drive length w=%0d", width), oe_len, 8);
      check("R8", $sformatf("reset length w=%0d", width), rst_len, 13);
      check(req, $sformatf("source w=%0d", width), src_v, exp_src);
      settle();
   endtask

   task automatic t_int(input logic w, input logic c, input int exp_src, input string req);
      int lat, oe_len, rst_len, src_v, co;
      fork
         begin
            wdog = w; cmon = c;
            @(negedge clk);
            wdog = 1'b0; cmon = 1'b0;
         end
         measure(lat, oe_len, rst_len, src_v, co);
      join
      check("R7", "internal start latency", lat, 1);
      check("R8", "pin_oe with chip_rst rise", co, 1);
      check("R3", "internal drive length", oe_len, 8);
      check("R8", "internal reset length", rst_len, 13);
      check(req, "internal source", src_v, exp_src);
      settle();
   endtask

   task automatic t_int_with_pad();
      int lat, oe_len, rst_len, src_v, co;
      fork
         begin
            wdog = 1'b1;
            @(negedge clk);
            wdog = 1'b0;
         end
         pulse_ext(16);
         measure(lat, oe_len, rst_len, src_v, co);
      join
      check("R7", "latency with pad also low", lat, 1);
      check("R7", "pad low at decision wins", src_v, 1);
      settle();
   endtask

   task automatic t_restart(input int gap, input int exp_oe, input int exp_rst, input string what);
      int lat, oe_len, rst_len, src_v, co;
      fork
         begin
            wdog = 1'b1;
            @(negedge clk);
            wdog = 1'b0;
            repeat (gap - 1) @(negedge clk);
            cmon = 1'b1;
            @(negedge clk);
            cmon = 1'b0;
         end
         measure(lat, oe_len, rst_len, src_v, co);
      join
      check("R10", {what, " drive cycles"}, oe_len, exp_oe);
      check("R10", {what, " reset length"}, rst_len, exp_rst);
      check("R10", {what, " cause replaced"}, src_v, 3);
      settle();
   endtask

   task automatic t_hold();
      int changed = 0;
      t_int(1'b1, 1'b0, 2, "R6");
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (src != 2'b10 || chip_rst) changed++;
      end
      check("R9", "source held while idle", changed, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_ext(1,  0, "R6");
      t_ext(12, 0, "R4");
      t_ext(13, 1, "R4");
      t_ext(16, 1, "R5");
      t_ext(30, 1, "R5");
      t_int(1'b1, 1'b0, 2, "R6");
      t_int(1'b0, 1'b1, 3, "R6");
      t_int(1'b1, 1'b1, 3, "R7");
      t_int_with_pad();
      t_restart(5,  13, 18, "restart in drive");
      t_restart(10, 16, 23, "restart in wait");
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule